// File: doc/BRIEF.md
# Integer ALU and Shifter

This is the combinational execute unit of a 32-bit processor. Each cycle it takes one decoded instruction (a primary opcode, a function code for register-form operations, a 5-bit shift amount, the two source register values and a 16-bit immediate) and produces the destination value together with a destination write strobe. It covers add and subtract, the bitwise logic operations, set-on-less-than in signed and unsigned flavours, load-upper-immediate, and logical-left, logical-right and arithmetic-right shifts. Each shift comes in a constant-amount form and a register-amount form.

There is no condition-flag register. A comparison stores the value 1 or 0 in the destination register, and a later branch tests that register. Immediate operands are widened inside the unit: arithmetic and compare forms use sign extension, and the bitwise forms use zero extension. Add and subtract always wrap, with no overflow trap. The destination index comes from the decoder, which has already chosen between the rd and rt fields. A write aimed at register 0 is suppressed, so that register always reads as zero.

Top module: `intAluTop`

## Requirements
- R1: With opcode 000000 and function code 100000 or 100001, `result` is `rsVal + rtVal` modulo 2^32.
- R2: With opcode 000000 and function code 100010 or 100011, `result` is `rsVal - rtVal` modulo 2^32.
- R3: With opcode 000000, function codes 100100, 100101, 100110 and 100111 give the bitwise AND, OR, XOR and NOR of `rsVal` and `rtVal`.
- R4: With opcode 000000, function code 101010 gives 1 when `rsVal` is less than `rtVal` as two's-complement numbers and 0 otherwise. Function code 101011 does the same comparison with both operands unsigned.
- R5: Opcodes 001000 and 001001 give `rsVal` plus the sign-extended immediate, wrapping. Opcode 001010 gives a signed compare of `rsVal` against the sign-extended immediate, and opcode 001011 gives an unsigned compare against that same sign-extended value. Each compare result is 1 or 0.
- R6: Opcodes 001100, 001101 and 001110 give the AND, OR and XOR of `rsVal` with the zero-extended immediate.
- R7: Opcode 001111 puts the immediate in bits 31:16 of `result` and clears bits 15:0.
- R8: With opcode 000000, function codes 000000, 000010 and 000011 shift `rtVal` left logically, right logically and right arithmetically by `shamt`.
- R9: With opcode 000000, function codes 000100, 000110 and 000111 perform the same three shifts of `rtVal`, using `rsVal[4:0]` as the amount. The upper bits of `rsVal` have no effect.
- R10: `writeEn` is high for every supported operation whose `destIdx` is nonzero, and it is low whenever `destIdx` is 0.
- R11: Any opcode outside the set above, or any function code under opcode 000000 outside the set above, gives `result` = 0 with `writeEn` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Primary opcode field |
| funct | input | 6 | Function code, used when opcode is 000000 |
| shamt | input | 5 | Constant shift amount |
| rsVal | input | 32 | First source operand |
| rtVal | input | 32 | Second source operand / shift source |
| imm | input | 16 | Immediate field |
| destIdx | input | 5 | Destination register index |
| result | output | 32 | Computed destination value |
| writeEn | output | 1 | Destination write strobe |

## Verification
The bench builds the unit with its default widths: 32-bit data, a 16-bit immediate and 5-bit register indices. This keeps the opcode and function-code spaces small enough to sweep every one of their 64 values against a set of corner operand pairs, including sign boundaries, all-ones and equal operands. It also makes it possible to try all 32 shift amounts in both shift forms, with junk in the upper amount bits, and all 32 destination indices.

// File: rtl/intAluPkg.sv
package intAluPkg;
  localparam int CODE_W = 6;

  localparam logic [CODE_W-1:0] OPC_REG   = 6'b000000;
  localparam logic [CODE_W-1:0] OPC_ADDI  = 6'b001000;
  localparam logic [CODE_W-1:0] OPC_ADDIU = 6'b001001;
  localparam logic [CODE_W-1:0] OPC_SLTI  = 6'b001010;
  localparam logic [CODE_W-1:0] OPC_SLTIU = 6'b001011;
  localparam logic [CODE_W-1:0] OPC_ANDI  = 6'b001100;
  localparam logic [CODE_W-1:0] OPC_ORI   = 6'b001101;
  localparam logic [CODE_W-1:0] OPC_XORI  = 6'b001110;
  localparam logic [CODE_W-1:0] OPC_LUI   = 6'b001111;

  localparam logic [CODE_W-1:0] FN_SLL  = 6'b000000;
  localparam logic [CODE_W-1:0] FN_SRL  = 6'b000010;
  localparam logic [CODE_W-1:0] FN_SRA  = 6'b000011;
  localparam logic [CODE_W-1:0] FN_SLLV = 6'b000100;
  localparam logic [CODE_W-1:0] FN_SRLV = 6'b000110;
  localparam logic [CODE_W-1:0] FN_SRAV = 6'b000111;
  localparam logic [CODE_W-1:0] FN_ADD  = 6'b100000;
  localparam logic [CODE_W-1:0] FN_ADDU = 6'b100001;
  localparam logic [CODE_W-1:0] FN_SUB  = 6'b100010;
  localparam logic [CODE_W-1:0] FN_SUBU = 6'b100011;
  localparam logic [CODE_W-1:0] FN_AND  = 6'b100100;
  localparam logic [CODE_W-1:0] FN_OR   = 6'b100101;
  localparam logic [CODE_W-1:0] FN_XOR  = 6'b100110;
  localparam logic [CODE_W-1:0] FN_NOR  = 6'b100111;
  localparam logic [CODE_W-1:0] FN_SLT  = 6'b101010;
  localparam logic [CODE_W-1:0] FN_SLTU = 6'b101011;

  typedef enum logic [3:0] {
    ALU_NONE, ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
    ALU_SLT, ALU_SLTU, ALU_LUI, ALU_SLL, ALU_SRL, ALU_SRA
  } aluOp_e;

  // Strobes from decode to datapath
  typedef struct packed {
    aluOp_e op;
    logic   useImm;     // second operand is the extended immediate
    logic   immSigned;  // sign- rather than zero-extend the immediate
    logic   varShift;   // shift amount taken from rsVal
    logic   valid;      // recognised operation
  } aluCtrl_t;
endpackage

// File: rtl/intAluControl.sv
module intAluControl
  import intAluPkg::*;
#(
  parameter int REG_IDX_W = 5
) (
  input  logic [CODE_W-1:0]    opcode,
  input  logic [CODE_W-1:0]    funct,
  input  logic [REG_IDX_W-1:0] destIdx,
  output aluCtrl_t             ctrl,
  output logic                 writeEn
);
  always_comb begin
    ctrl.op        = ALU_NONE;
    ctrl.useImm    = 1'b0;
    ctrl.immSigned = 1'b0;
    ctrl.varShift  = 1'b0;
    ctrl.valid     = 1'b1;
    unique case (opcode)
      OPC_REG: begin
        unique case (funct)
          FN_ADD, FN_ADDU: ctrl.op = ALU_ADD;
          FN_SUB, FN_SUBU: ctrl.op = ALU_SUB;
          FN_AND:  ctrl.op = ALU_AND;
          FN_OR:   ctrl.op = ALU_OR;
          FN_XOR:  ctrl.op = ALU_XOR;
          FN_NOR:  ctrl.op = ALU_NOR;
          FN_SLT:  ctrl.op = ALU_SLT;
          FN_SLTU: ctrl.op = ALU_SLTU;
          FN_SLL:  ctrl.op = ALU_SLL;
          FN_SRL:  ctrl.op = ALU_SRL;
          FN_SRA:  ctrl.op = ALU_SRA;
          FN_SLLV: begin ctrl.op = ALU_SLL; ctrl.varShift = 1'b1; end
          FN_SRLV: begin ctrl.op = ALU_SRL; ctrl.varShift = 1'b1; end
          FN_SRAV: begin ctrl.op = ALU_SRA; ctrl.varShift = 1'b1; end
          default: ctrl.valid = 1'b0;
        endcase
      end
      OPC_ADDI, OPC_ADDIU: begin
        ctrl.op = ALU_ADD; ctrl.useImm = 1'b1; ctrl.immSigned = 1'b1;
      end
      OPC_SLTI: begin
        ctrl.op = ALU_SLT; ctrl.useImm = 1'b1; ctrl.immSigned = 1'b1;
      end
      OPC_SLTIU: begin
        ctrl.op = ALU_SLTU; ctrl.useImm = 1'b1; ctrl.immSigned = 1'b1;
      end
      OPC_ANDI: begin ctrl.op = ALU_AND; ctrl.useImm = 1'b1; end
      OPC_ORI:  begin ctrl.op = ALU_OR;  ctrl.useImm = 1'b1; end
      OPC_XORI: begin ctrl.op = ALU_XOR; ctrl.useImm = 1'b1; end
      OPC_LUI:  ctrl.op = ALU_LUI;
      default:  ctrl.valid = 1'b0;
    endcase
  end

  assign writeEn = ctrl.valid && (destIdx != '0);
endmodule

// File: rtl/intAluDatapath.sv
module intAluDatapath
  import intAluPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  aluCtrl_t          ctrl,
  input  logic [SH_W-1:0]   shamt,
  input  logic [DATA_W-1:0] rsVal,
  input  logic [DATA_W-1:0] rtVal,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] result
);
  localparam int EXT_W = DATA_W - IMM_W;
  localparam int MSB   = DATA_W - 1;

  logic [DATA_W-1:0] immExt, opB, addIn, shl, shr, sra, luiVal;
  logic [DATA_W:0]   addFull;
  logic              doSub, lessS, lessU;
  logic [SH_W-1:0]   shAmt;

  assign immExt = ctrl.immSigned ? {{EXT_W{imm[IMM_W-1]}}, imm}
                                 : {{EXT_W{1'b0}}, imm};
  assign opB    = ctrl.useImm ? immExt : rtVal;

  // One carry chain serves add, subtract and both compares
  assign doSub   = (ctrl.op == ALU_SUB) || (ctrl.op == ALU_SLT) || (ctrl.op == ALU_SLTU);
  assign addIn   = doSub ? ~opB : opB;
  assign addFull = {1'b0, rsVal} + {1'b0, addIn} + {{DATA_W{1'b0}}, doSub};
  assign lessU   = ~addFull[DATA_W];
  assign lessS   = (rsVal[MSB] ^ opB[MSB]) ? rsVal[MSB] : addFull[MSB];

  assign shAmt  = ctrl.varShift ? rsVal[SH_W-1:0] : shamt;
  assign shl    = rtVal << shAmt;
  assign shr    = rtVal >> shAmt;
  assign sra    = DATA_W'($signed(rtVal) >>> shAmt);
  assign luiVal = {imm, {EXT_W{1'b0}}};

  always_comb begin
    unique case (ctrl.op)
      ALU_ADD, ALU_SUB: result = addFull[DATA_W-1:0];
      ALU_AND:  result = rsVal & opB;
      ALU_OR:   result = rsVal | opB;
      ALU_XOR:  result = rsVal ^ opB;
      ALU_NOR:  result = ~(rsVal | opB);
      ALU_SLT:  result = {{(DATA_W-1){1'b0}}, lessS};
      ALU_SLTU: result = {{(DATA_W-1){1'b0}}, lessU};
      ALU_LUI:  result = luiVal;
      ALU_SLL:  result = shl;
      ALU_SRL:  result = shr;
      ALU_SRA:  result = sra;
      default:  result = '0;
    endcase
  end
endmodule

// File: rtl/intAluTop.sv
module intAluTop
  import intAluPkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IMM_W     = 16,
  parameter int REG_IDX_W = 5,
  localparam int SH_W     = $clog2(DATA_W)
) (
  input  logic [CODE_W-1:0]    opcode,
  input  logic [CODE_W-1:0]    funct,
  input  logic [SH_W-1:0]      shamt,
  input  logic [DATA_W-1:0]    rsVal,
  input  logic [DATA_W-1:0]    rtVal,
  input  logic [IMM_W-1:0]     imm,
  input  logic [REG_IDX_W-1:0] destIdx,
  output logic [DATA_W-1:0]    result,
  output logic                 writeEn
);
  aluCtrl_t ctrl;

  intAluControl #(.REG_IDX_W(REG_IDX_W)) uCtrl (
    .opcode(opcode), .funct(funct), .destIdx(destIdx),
    .ctrl(ctrl), .writeEn(writeEn)
  );

  intAluDatapath #(.DATA_W(DATA_W), .IMM_W(IMM_W)) uPath (
    .ctrl(ctrl), .shamt(shamt), .rsVal(rsVal), .rtVal(rtVal),
    .imm(imm), .result(result)
  );
endmodule

// File: rtl/intAluChecker.sv
module intAluChecker
  import intAluPkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IMM_W     = 16,
  parameter int REG_IDX_W = 5
) (
  input logic [CODE_W-1:0]    opcode,
  input logic [CODE_W-1:0]    funct,
  input logic [DATA_W-1:0]    rsVal,
  input logic [IMM_W-1:0]     imm,
  input logic [REG_IDX_W-1:0] destIdx,
  input logic [DATA_W-1:0]    result,
  input logic                 writeEn
);
  logic isCompare;
  assign isCompare = (opcode == OPC_SLTI) || (opcode == OPC_SLTIU) ||
                     ((opcode == OPC_REG) && ((funct == FN_SLT) || (funct == FN_SLTU)));

  always_comb begin
    if (destIdx == '0)
      assert_r0_discard_R10: assert (!writeEn)
        else $error("write strobe raised for register 0");
    if (!writeEn && destIdx != '0)
      assert_unsupported_zero_R11: assert (result == '0)
        else $error("rejected operation left nonzero result");
    if (isCompare)
      assert_compare_bool_R4: assert (result[DATA_W-1:1] == '0)
        else $error("compare result not 0 or 1");
    if (opcode == OPC_LUI)
      assert_lui_layout_R7: assert (result == {imm, {(DATA_W-IMM_W){1'b0}}})
        else $error("load-upper layout wrong");
    if (opcode == OPC_ANDI)
      assert_andi_upper_R6: assert (result[DATA_W-1:IMM_W] == '0)
        else $error("and-immediate upper bits not cleared");
    if (opcode == OPC_ORI || opcode == OPC_XORI)
      assert_ori_xori_upper_R6: assert (result[DATA_W-1:IMM_W] == rsVal[DATA_W-1:IMM_W])
        else $error("or/xor-immediate disturbed upper bits");
  end
endmodule

bind intAluTop intAluChecker #(.DATA_W(DATA_W), .IMM_W(IMM_W), .REG_IDX_W(REG_IDX_W)) uChk (
  .opcode(opcode), .funct(funct), .rsVal(rsVal), .imm(imm),
  .destIdx(destIdx), .result(result), .writeEn(writeEn)
);

// File: tb/tb_intAluTop.sv
module tb_intAluTop;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [5:0]  opcode, funct;
  logic [4:0]  shamt, destIdx;
  logic [31:0] rsVal, rtVal, result;
  logic [15:0] imm;
  logic        writeEn;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  intAluTop dut (
    .opcode(opcode), .funct(funct), .shamt(shamt), .rsVal(rsVal), .rtVal(rtVal),
    .imm(imm), .destIdx(destIdx), .result(result), .writeEn(writeEn)
  );

  function automatic logic [31:0] patA(int i);
    case (i)
      0: return 32'h0000_0000; 1: return 32'h0000_0001; 2: return 32'h8000_0000;
      3: return 32'h7FFF_FFFF; 4: return 32'h1234_5678; default: return 32'hFFFF_FFFB;
    endcase
  endfunction
  function automatic logic [31:0] patB(int i);
    case (i)
      0: return 32'h0000_0000; 1: return 32'hFFFF_FFFF; 2: return 32'h0000_0001;
      3: return 32'h8000_0000; 4: return 32'h9ABC_DEF0; default: return 32'hFFFF_FFFB;
    endcase
  endfunction

  function automatic string regTag(logic [5:0] fn);
    case (fn)
      6'd32, 6'd33: return "R1";
      6'd34, 6'd35: return "R2";
      6'd36, 6'd37, 6'd38, 6'd39: return "R3";
      6'd42, 6'd43: return "R4";
      6'd0, 6'd2, 6'd3: return "R8";
      6'd4, 6'd6, 6'd7: return "R9";
      default: return "R11";
    endcase
  endfunction
  function automatic string immTag(logic [5:0] op);
    case (op)
      6'd8, 6'd9, 6'd10, 6'd11: return "R5";
      6'd12, 6'd13, 6'd14: return "R6";
      6'd15: return "R7";
      default: return "R11";
    endcase
  endfunction

  // Reference computed straight from the requirement text
  task automatic model(output logic [31:0] r, output logic we);
    logic [31:0] sx, zx;
    logic ok;
    sx = {{16{imm[15]}}, imm};
    zx = {16'h0, imm};
    ok = 1'b1;
    r  = 32'h0;
    if (opcode == 6'd0) begin
      case (funct)
        6'd32, 6'd33: r = rsVal + rtVal;
        6'd34, 6'd35: r = rsVal - rtVal;
        6'd36: r = rsVal & rtVal;
        6'd37: r = rsVal | rtVal;
        6'd38: r = rsVal ^ rtVal;
        6'd39: r = ~(rsVal | rtVal);
        6'd42: r = ($signed(rsVal) < $signed(rtVal)) ? 32'd1 : 32'd0;
        6'd43: r = (rsVal < rtVal) ? 32'd1 : 32'd0;
        6'd0:  r = rtVal << shamt;
        6'd2:  r = rtVal >> shamt;
        6'd3:  r = $signed(rtVal) >>> shamt;
        6'd4:  r = rtVal << rsVal[4:0];
        6'd6:  r = rtVal >> rsVal[4:0];
        6'd7:  r = $signed(rtVal) >>> rsVal[4:0];
        default: ok = 1'b0;
      endcase
    end else begin
      case (opcode)
        6'd8, 6'd9: r = rsVal + sx;
        6'd10: r = ($signed(rsVal) < $signed(sx)) ? 32'd1 : 32'd0;
        6'd11: r = (rsVal < sx) ? 32'd1 : 32'd0;
        6'd12: r = rsVal & zx;
        6'd13: r = rsVal | zx;
        6'd14: r = rsVal ^ zx;
        6'd15: r = {imm, 16'h0};
        default: ok = 1'b0;
      endcase
    end
    if (!ok) r = 32'h0;
    we = ok && (destIdx != 5'd0);
  endtask

  task automatic apply(logic [5:0] op, logic [5:0] fn, logic [4:0] sa,
                       logic [31:0] a, logic [31:0] b, logic [15:0] im, logic [4:0] dst);
    @(posedge clk);
    opcode = op; funct = fn; shamt = sa; rsVal = a; rtVal = b; imm = im; destIdx = dst;
    @(negedge clk);
  endtask

  task automatic checkNow(string tag);
    logic [31:0] er;
    logic ew;
    model(er, ew);
    checks++;
    if (result !== er || writeEn !== ew) begin
      errors++;
      $display("FAIL %s op=%b fn=%b sa=%0d rs=%h rt=%h imm=%h dst=%0d : result=%h we=%b expected result=%h we=%b",
               tag, opcode, funct, shamt, rsVal, rtVal, imm, destIdx, result, writeEn, er, ew);
    end
  endtask

  initial begin
    opcode = '0; funct = '0; shamt = '0; rsVal = '0; rtVal = '0; imm = '0; destIdx = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // idle inputs: shift of zero into register 0, no write (R10)
    checkNow("R10");

    // every function code under opcode 000000 (R1 R2 R3 R4 R8 R11)
    for (int fn = 0; fn < 64; fn++)
      for (int p = 0; p < 6; p++) begin
        apply(6'd0, 6'(fn), 5'(p * 7), patA(p), patB(p), 16'h0, 5'd9);
        checkNow(regTag(6'(fn)));
        apply(6'd0, 6'(fn), 5'(31 - p), patB(p), patA(p), 16'h0, 5'd3);
        checkNow(regTag(6'(fn)));
      end

    // every nonzero opcode against immediates of both signs (R5 R6 R7 R11)
    for (int op = 1; op < 64; op++)
      for (int p = 0; p < 6; p++) begin
        apply(6'(op), 6'd32, 5'd0, patA(p), 32'h0, patB(p + 1)[15:0] ^ 16'(p * 16'h3210), 5'd17);
        checkNow(immTag(6'(op)));
        apply(6'(op), 6'd32, 5'd0, patB(p), 32'h0, 16'h8000 >> p, 5'd17);
        checkNow(immTag(6'(op)));
      end
    // unsigned compare against sign-extended 0xFFFF and 0x8000 edges (R5)
    apply(6'd11, 6'd0, 5'd0, 32'hFFFF_FFFE, 32'h0, 16'hFFFF, 5'd2); checkNow("R5");
    apply(6'd11, 6'd0, 5'd0, 32'hFFFF_FFFF, 32'h0, 16'hFFFF, 5'd2); checkNow("R5");
    apply(6'd10, 6'd0, 5'd0, 32'hFFFF_8000, 32'h0, 16'h8000, 5'd2); checkNow("R5");

    // all constant shift amounts (R8) and all register amounts with junk upper bits (R9)
    for (int s = 0; s < 32; s++)
      for (int k = 0; k < 3; k++) begin
        apply(6'd0, 6'd0 + 6'(k == 0 ? 0 : k + 1), 5'(s), 32'hDEAD_BEEF, 32'hC3A5_0F81 >> k, 16'h0, 5'd5);
        checkNow("R8");
        apply(6'd0, 6'd4 + 6'(k == 0 ? 0 : k + 1), 5'(31 - s), {27'h5A5A5A5 >> k, 5'(s)},
              32'h8421_F00F << k, 16'h0, 5'd5);
        checkNow("R9");
      end

    // every destination index with a valid add and an invalid code (R10 R11)
    for (int d = 0; d < 32; d++) begin
      apply(6'd0, 6'd33, 5'd0, 32'h10, 32'h20, 16'h0, 5'(d));
      checkNow("R10");
      apply(6'd0, 6'd1, 5'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 5'(d));
      checkNow("R11");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired before sweep completed (all requirements)");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule